// File: doc/BRIEF.md
# One-Time-Programmable Memory Burn Sequencer

This controller writes every location of a byte-wide one-time-programmable memory from a local source buffer. A single `start` pulse runs the whole job. The controller raises the supply-high request and then the programming-voltage request. It then gives each address one program strobe in ascending order, with no check between strobes.

A second pass reads each address back. A byte that does not match gets further strobes, and it is read again after each one. When every byte has matched, the controller drops the programming voltage and then the supply-high rail. It then reads the whole array at normal levels and compares it with the buffer.

All timing windows are counted in clock cycles and derived from the `CLK_HZ` parameter: strobe width, setup times, read sampling delay and bus turnaround. The result is a one-cycle `done`, with `pass` and the first failing address.

Top module: `otp_prog_seq`

## Requirements
- R1: Each program strobe (`prog_strobe` high) lasts exactly PULSE_CYC = round(CLK_HZ / 10000) cycles. This is 100 µs, inside the 95 to 105 µs window.
- R2: `vpp_req` is never high while `vcc_hi_req` is low. `vcc_hi_req` rises at least SETUP_CYC = ceil(2 µs · CLK_HZ) cycles before `vpp_req`. On a normal finish, `vpp_req` falls at least SETUP_CYC cycles before `vcc_hi_req`.
- R3: The first pass gives addresses 0 to 2^ADDR_W−1, in ascending order, exactly one strobe each, and `mem_oe` stays low throughout.
- R4: The second pass reads each address in ascending order. On a mismatch it strobes again and re-reads, for at most MAX_RETRY (10) extra strobes per byte. A byte that needs 11 strobes in total still passes.
- R5: If a byte still mismatches after its 10th extra strobe, the run ends with `pass` = 0 and `fail_addr` = that address. Later addresses get no further strobes.
- R6: After the second pass, both rails are low. Every address is then read and compared with the buffer. The first mismatch ends the run with `pass` = 0 and `fail_addr` = that address.
- R7: Before a strobe rises, `mem_addr` and `mem_dout` have been held with `mem_dout_en` high for at least SETUP_CYC cycles, and `vpp_req` has been high for at least SETUP_CYC cycles.
- R8: Each read holds `mem_oe` high for OE_CYC = ceil(150 ns · CLK_HZ) cycles before `mem_din` is sampled. `mem_dout_en` and `mem_oe` are never high together. After `mem_oe` falls, `mem_dout_en` stays low for at least FLT_CYC = ceil(130 ns · CLK_HZ) cycles.
- R9: A `start` pulse while `busy` is high has no effect on the run: the same strobes, one `done`, the same result.
- R10: `abort` drives `prog_strobe`, `vpp_req`, `vcc_hi_req` and `busy` low from the next clock. No `done` follows, and the sequencer waits for a new `start`.
- R11: After reset, and after a run, the sequencer is idle with all memory-side controls low. `done` is high for one cycle per run, with `pass` valid in that cycle and `fail_addr` held until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| abort | input | 1 | Stop at once and return to idle |
| src_addr | output | ADDR_W | Source buffer read address |
| src_data | input | DATA_W | Source byte for `src_addr`, valid in the same cycle |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Byte driven toward the memory |
| mem_dout_en | output | 1 | Enable for `mem_dout` on the shared data bus |
| mem_din | input | DATA_W | Byte read from the memory |
| prog_strobe | output | 1 | Program strobe, active high |
| mem_oe | output | 1 | Memory output enable, active high |
| vcc_hi_req | output | 1 | Request for the raised supply level |
| vpp_req | output | 1 | Request for the programming voltage |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run flag |
| pass | output | 1 | Result, valid while `done` is high |
| fail_addr | output | ADDR_W | First failing address |

## Verification
The assertions assume the following:
- `abort` is the only way a strobe ends early.
- `src_data` follows `src_addr` within the same cycle.
- `rst_n` is held low across the first clock edges.

The bench meets these in the following ways:
- It drives `src_data` from a combinational lookup into its own buffer.
- It asserts `abort` only in the abort scenario, and its strobe-width check steps aside for that one strobe.
- It holds reset for five cycles.

Its memory stub returns the inverted byte until `mem_oe` has been high for OE_CYC cycles. It only accepts a byte after a set number of strobes, so the retry counts come from chosen per-address strobe thresholds. Source bytes are random with bit 0 cleared, which means an unprogrammed byte can never match by chance.

// File: rtl/otp_prog_seq.sv
`timescale 1ns/1ps
module otp_prog_seq #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CLK_HZ    = 50_000_000,
  parameter int MAX_RETRY = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din,
  output logic              prog_strobe,
  output logic              mem_oe,
  output logic              vcc_hi_req,
  output logic              vpp_req,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam longint HZ   = longint'(CLK_HZ);
  localparam int PULSE_CYC = int'((HZ + 5000) / 10000);
  localparam int SETUP_RAW = int'((2 * HZ + 999_999) / 1_000_000);
  localparam int OE_RAW    = int'((15 * HZ + 99_999_999) / 100_000_000);
  localparam int FLT_RAW   = int'((13 * HZ + 99_999_999) / 100_000_000);
  localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
  localparam int OE_CYC    = (OE_RAW < 1) ? 1 : OE_RAW;
  localparam int FLT_CYC   = (FLT_RAW < 1) ? 1 : FLT_RAW;
  localparam int TW        = $clog2(PULSE_CYC + 1);
  localparam int RW        = $clog2(MAX_RETRY + 1);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  typedef enum logic [3:0] {
    S_IDLE, S_VCC_UP, S_VPP_UP, S_SET, S_PULSE, S_VFY, S_VFLT,
    S_VPP_DN, S_VCC_DN, S_RD, S_RFLT, S_DONE
  } state_t;

  state_t            state;
  logic [ADDR_W-1:0] addr;
  logic [TW-1:0]     tmr, lim;
  logic [RW-1:0]     retry;
  logic              second, failed, miss;
  logic              td;

  always_comb begin
    case (state)
      S_PULSE:      lim = TW'(PULSE_CYC - 1);
      S_VFY, S_RD:  lim = TW'(OE_CYC - 1);
      S_VFLT, S_RFLT: lim = TW'(FLT_CYC - 1);
      default:      lim = TW'(SETUP_CYC - 1);
    endcase
  end
  assign td = (tmr == lim);

  assign src_addr    = addr;
  assign mem_addr    = addr;
  assign mem_dout    = src_data;
  assign mem_dout_en = (state == S_SET) || (state == S_PULSE);
  assign prog_strobe = (state == S_PULSE);
  assign mem_oe      = (state == S_VFY) || (state == S_RD);
  assign vcc_hi_req  = (state != S_IDLE) && (state != S_VCC_DN) && (state != S_RD)
                       && (state != S_RFLT) && (state != S_DONE);
  assign vpp_req     = vcc_hi_req && (state != S_VCC_UP) && (state != S_VPP_DN);
  assign busy        = (state != S_IDLE);
  assign done        = (state == S_DONE);
  assign pass        = done && !failed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; addr <= '0; tmr <= '0; retry <= '0;
      second <= 1'b0; failed <= 1'b0; miss <= 1'b0; fail_addr <= '0;
    end else if (abort) begin
      state <= S_IDLE; tmr <= '0;
    end else begin
      tmr <= td ? '0 : tmr + 1'b1;
      case (state)
        S_IDLE: begin
          tmr <= '0;
          if (start) begin
            addr <= '0; retry <= '0; second <= 1'b0; failed <= 1'b0;
            fail_addr <= '0; state <= S_VCC_UP;
          end
        end
        S_VCC_UP: if (td) state <= S_VPP_UP;
        S_VPP_UP: if (td) state <= S_SET;
        S_SET:    if (td) state <= S_PULSE;
        S_PULSE: if (td) begin
          if (second) state <= S_VFY;
          else if (addr == LAST) begin
            second <= 1'b1; addr <= '0; state <= S_VFY;
          end else begin
            addr <= addr + 1'b1; state <= S_SET;
          end
        end
        S_VFY: if (td) begin
          miss <= (mem_din != src_data); state <= S_VFLT;
        end
        S_VFLT: if (td) begin
          if (!miss) begin
            retry <= '0;
            if (addr == LAST) state <= S_VPP_DN;
            else begin addr <= addr + 1'b1; state <= S_VFY; end
          end else if (retry == RW'(MAX_RETRY)) begin
            failed <= 1'b1; fail_addr <= addr; state <= S_VPP_DN;
          end else begin
            retry <= retry + 1'b1; state <= S_SET;
          end
        end
        S_VPP_DN: if (td) state <= S_VCC_DN;
        S_VCC_DN: if (td) begin
          if (failed) state <= S_DONE;
          else begin addr <= '0; state <= S_RD; end
        end
        S_RD: if (td) begin
          miss <= (mem_din != src_data); state <= S_RFLT;
        end
        S_RFLT: if (td) begin
          if (miss) begin
            failed <= 1'b1; fail_addr <= addr; state <= S_DONE;
          end else if (addr == LAST) state <= S_DONE;
          else begin addr <= addr + 1'b1; state <= S_RD; end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [TW:0] pw_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pw_q <= '0;
    else pw_q <= prog_strobe ? pw_q + 1'b1 : '0;

  assert_strobe_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(prog_strobe) && !$past(abort)) |-> (pw_q == (TW+1)'(PULSE_CYC)));
  assert_rail_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_req |-> vcc_hi_req);
  assert_retry_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    retry <= RW'(MAX_RETRY));
  assert_pulse_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_strobe) |-> ($past(mem_dout_en) && $past(vpp_req) && $stable(mem_addr)));
  assert_bus_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dout_en && mem_oe));
  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !prog_strobe && !vpp_req && !vcc_hi_req));
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
endmodule

// File: tb/otp_prog_seq_test.sv
`timescale 1ns/1ps
module otp_prog_seq_test;
  localparam int AW = 3, DW = 8, N = 8, HZ = 10_000_000;
  localparam int PC = 1000, SC = 20, OC = 2, FC = 2;

  logic clk = 0, rst_n = 0, start = 0, abort = 0;
  logic [AW-1:0] src_addr, mem_addr, fail_addr;
  logic [DW-1:0] src_data, mem_dout, mem_din;
  logic mem_dout_en, prog_strobe, mem_oe, vcc_hi_req, vpp_req, busy, done, pass;

  otp_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_HZ(HZ), .MAX_RETRY(10)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .src_addr(src_addr), .src_data(src_data), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din),
    .prog_strobe(prog_strobe), .mem_oe(mem_oe), .vcc_hi_req(vcc_hi_req),
    .vpp_req(vpp_req), .busy(busy), .done(done), .pass(pass), .fail_addr(fail_addr));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] src[N], mem[N];
  int need[N], pcnt[N], seq[N];
  int corrupt = -1, oe_cnt = 0;
  logic [7:0] rdv;

  assign src_data = src[src_addr];
  assign rdv = mem[mem_addr] ^ ((!vpp_req && corrupt == int'(mem_addr)) ? 8'h01 : 8'h00);
  assign mem_din = (mem_oe && oe_cnt >= OC - 1) ? rdv : ~rdv;
  always @(posedge clk) oe_cnt <= mem_oe ? oe_cnt + 1 : 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  bit pst, pvpp, pvcc, poe, pden, aborting, done_pass;
  logic [AW-1:0] paddr, last_addr, done_fa;
  logic [7:0] pdata;
  int w, setc, vppc, vccc, vpplo, oelo = 100, seqn, oe_p1, contention, done_cnt;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prog_strobe && !pst) begin
        check(setc >= SC, "R7 address/data setup", setc, SC);
        check(vppc >= SC, "R7 programming voltage setup", vppc, SC);
      end
      if (prog_strobe) begin w++; paddr = mem_addr; pdata = mem_dout; end
      if (!prog_strobe && pst) begin
        if (!aborting) begin
          check(w == PC, "R1 strobe width", w, PC);
          pcnt[paddr]++;
          if (pcnt[paddr] >= need[paddr]) mem[paddr] &= pdata;
          if (seqn < N) seq[seqn] = int'(paddr);
          seqn++;
        end
        w = 0;
      end
      if (vpp_req && !pvpp) check(vccc >= SC, "R2 supply raised first", vccc, SC);
      if (!vcc_hi_req && pvcc && !aborting)
        check(vpplo >= SC, "R2 programming voltage released first", vpplo, SC);
      if (mem_dout_en && !pden) check(oelo >= FC, "R8 bus turnaround", oelo, FC);
      if (mem_dout_en && mem_oe) contention++;
      if (mem_oe && !poe && seqn < N) oe_p1++;
      if (done) begin done_cnt++; done_pass = pass; done_fa = fail_addr; end
      setc  = (mem_dout_en && !prog_strobe) ?
              ((pden && !pst && mem_addr == last_addr) ? setc + 1 : 1) : 0;
      vppc  = vpp_req ? vppc + 1 : 0;
      vccc  = vcc_hi_req ? vccc + 1 : 0;
      vpplo = vpp_req ? 0 : vpplo + 1;
      oelo  = mem_oe ? 0 : oelo + 1;
      pst = prog_strobe; pvpp = vpp_req; pvcc = vcc_hi_req;
      poe = mem_oe; pden = mem_dout_en; last_addr = mem_addr;
    end
  end

  task automatic prep();
    for (int i = 0; i < N; i++) begin mem[i] = 8'hFF; pcnt[i] = 0; seq[i] = -1; end
    seqn = 0; oe_p1 = 0; contention = 0; done_cnt = 0; aborting = 0;
  endtask

  task automatic new_src();
    for (int i = 0; i < N; i++) src[i] = 8'($urandom()) & 8'hFE;
  endtask

  task automatic rand_need(input int maxn);
    for (int i = 0; i < N; i++) need[i] = 1 + int'($urandom_range(maxn - 1));
  endtask

  task automatic do_run(input bit poke, input string tag);
    int ep[N];
    int stop;
    bit exp_pass;
    int exp_fa;
    prep();
    stop = -1;
    for (int a = 0; a < N; a++) begin
      if (stop >= 0 || need[a] <= 1) ep[a] = 1;
      else if (need[a] <= 11) ep[a] = need[a];
      else begin ep[a] = 11; stop = a; end
    end
    exp_pass = (stop < 0) && (corrupt < 0);
    exp_fa = (stop >= 0) ? stop : corrupt;
    @(posedge clk); #1 start = 1; @(posedge clk); #1 start = 0;
    if (poke) begin
      while (!(seqn >= N + 2 && mem_oe)) @(negedge clk);
      @(posedge clk); #1 start = 1; @(posedge clk); #1 start = 0;
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    for (int a = 0; a < N; a++)
      check(pcnt[a] == ep[a], {tag, " strobes per address (R4)"}, pcnt[a], ep[a]);
    if (stop < 0)
      for (int a = 0; a < N; a++)
        check(mem[a] == src[a], {tag, " programmed byte (R3)"}, mem[a], src[a]);
    for (int i = 0; i < N; i++) check(seq[i] == i, "R3 first pass order", seq[i], i);
    check(oe_p1 == 0, "R3 no read during first pass", oe_p1, 0);
    check(contention == 0, "R8 bus never driven by both sides", contention, 0);
    check(done_cnt == 1, {tag, " single done (R11)"}, done_cnt, 1);
    check(done_pass == exp_pass, {tag, " pass flag"}, done_pass, exp_pass);
    if (!exp_pass) check(int'(done_fa) == exp_fa, {tag, " failing address"}, done_fa, exp_fa);
    check(!busy && !vpp_req && !vcc_hi_req, "R11 idle after run", busy, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin need[i] = 1; src[i] = 8'h00; end
    prep();
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !prog_strobe && !mem_oe && !mem_dout_en &&
          !vpp_req && !vcc_hi_req, "R11 reset state", busy, 0);

    new_src(); rand_need(2); do_run(0, "R4 random");
    new_src(); rand_need(1); need[5] = 11; do_run(0, "R4 ten retries");
    new_src(); rand_need(3); need[2] = 12; do_run(0, "R5 retry exhaustion");
    new_src(); rand_need(1); corrupt = 6; do_run(0, "R6 read-back mismatch");
    corrupt = -1;
    new_src(); rand_need(3); do_run(1, "R9 start while busy");

    new_src(); rand_need(1); prep();
    @(posedge clk); #1 start = 1; @(posedge clk); #1 start = 0;
    while (!(prog_strobe && seqn == 3)) @(negedge clk);
    aborting = 1;
    @(posedge clk); #1 abort = 1;
    @(posedge clk); #1 abort = 0;
    @(negedge clk);
    check(!prog_strobe && !vpp_req && !vcc_hi_req && !busy, "R10 abort stops run",
          {prog_strobe, vpp_req, vcc_hi_req, busy}, 0);
    repeat (50) @(negedge clk);
    check(!busy && done_cnt == 0, "R10 stays idle, no done", done_cnt, 0);

    new_src(); rand_need(2); do_run(0, "R10 restart after abort");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule